// File: doc/BRIEF.md
# Wall-Clock Scheduled Pulse Generator

This block drives a single output line whose edges are scheduled against a free-running wall-clock time supplied from outside. The time is a seconds count plus a nanosecond count that wraps at one billion. Software sets a start time, an active duration, an inactive duration, the output polarity, absolute or relative start, and single or repeating operation. It then writes a start command. The block produces one pulse, an endless pulse train, or a square wave that toggles at fixed intervals. A sticky done flag reports the end of generation.

Every setting is copied into the sequencer when a start command is accepted. Register writes made during a run do not reach the output. A stop command on a repeating run takes effect only at the end of the next inactive interval. The register port is a plain write strobe plus a combinational read mux. There is no streamed data, so no valid/ready handshake is present and no back-pressure applies.

Top module: `wallclock_pulse_gen`

## Requirements
- R1: After reset, `pulse_out` is 0, `done` is 0 and the status register (address 1) reads 0 (bit 0 = done, bit 1 = busy).
- R2: In absolute mode (control bit 3 = 0), the output leaves its inactive level on the first cycle after the sampled wall time is greater than or equal to the programmed start time. Until then it holds the inactive level.
- R3: In relative mode (control bit 3 = 1), the effective start is the wall time sampled at the start write plus the programmed start value.
- R4: With repeat off (control bit 2 = 0) and a non-zero width, the output is active from start to start+width and inactive after that. Done is set at start+width+idle.
- R5: Control bit 4 = 1 selects an active-low output. At an accepted start, the output goes to the inactive level of the new polarity.
- R6: A zero width selects toggle mode. In single mode the output inverts once at the start time and holds that level, and done is set at start+idle. In repeat mode the output inverts again at every idle interval.
- R7: With repeat on, each period is width active followed by idle inactive. A stop command (control bit 1) ends the run at the first period boundary later than the wall time sampled at the stop write. The output holds its level there, and done is set exactly once.
- R8: A start command (control bit 0) written while a run is busy is ignored, and register writes during a run do not change the output.
- R9: All deadline sums carry into seconds when the nanosecond sum reaches 1,000,000,000, including a carry across bit 31 of the seconds.
- R10: Done is sticky. Writing 1 to status bit 0 clears it, and so does an accepted start.
- R11: A start time that is already in the past fires on the first compare cycle after the start.
- Register map: 0 control, 1 status, 2 start nanoseconds, 3 start seconds bits 31:0, 4 start seconds bits 47:32, 5 width ns, 6 idle ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wall_sec | input | 48 | Wall-clock seconds |
| wall_ns | input | 30 | Wall-clock nanoseconds, below 1e9 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pulse_out | output | 1 | Generated output line |
| done | output | 1 | Sticky completion flag |

## Verification
Every cycle, assertions check the following. The scheduled deadline stays normalised below one billion nanoseconds. The output never moves while the sequencer waits for the start time. Done only rises out of an inactive interval and is never set while busy. The latched configuration cannot change while busy. Only the bench scenarios can show that edges land at the right wall times. They cover relative start sums, carry across the seconds words, the exact stop boundary and the polarity inversion. The bench checks these against a closed-form model of level versus wall time.

// File: rtl/wcp_pkg.sv
package wcp_pkg;
  parameter int SEC_W  = 48;
  parameter int NS_W   = 30;
  parameter int DUR_W  = 30;
  parameter int REG_AW = 3;
  parameter int REG_DW = 32;
  localparam int HI_W = SEC_W - 32;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] A_ST_NS = 3'd2;
  localparam logic [REG_AW-1:0] A_ST_LO = 3'd3;
  localparam logic [REG_AW-1:0] A_ST_HI = 3'd4;
  localparam logic [REG_AW-1:0] A_WIDTH = 3'd5;
  localparam logic [REG_AW-1:0] A_GAP   = 3'd6;

  localparam int B_START = 0;
  localparam int B_STOP  = 1;
  localparam int B_REP   = 2;
  localparam int B_REL   = 3;
  localparam int B_INV   = 4;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;

  typedef struct packed {
    tod_t             start;
    logic [DUR_W-1:0] width;
    logic [DUR_W-1:0] gap;
    logic             rep;
    logic             rel;
    logic             inv;
  } cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACT, S_GAP} seq_state_t;
endpackage

// File: rtl/wcp_tod_add.sv
module wcp_tod_add
  import wcp_pkg::*;
(
  input  tod_t             a,
  input  logic [SEC_W-1:0] b_sec,
  input  logic [DUR_W-1:0] b_ns,
  output tod_t             y
);
  localparam int SUM_W = ((NS_W > DUR_W) ? NS_W : DUR_W) + 2;
  localparam logic [SUM_W-1:0] ONE_S = SUM_W'(NS_PER_SEC);
  localparam logic [SUM_W-1:0] TWO_S = SUM_W'({1'b0, NS_PER_SEC} << 1);

  logic [SUM_W-1:0] raw;
  logic [SUM_W-1:0] fixed;
  logic [1:0]       wrap;

  always_comb begin
    raw = SUM_W'(a.ns) + SUM_W'(b_ns);
    if (raw >= TWO_S) begin
      wrap  = 2'd2;
      fixed = raw - TWO_S;
    end else if (raw >= ONE_S) begin
      wrap  = 2'd1;
      fixed = raw - ONE_S;
    end else begin
      wrap  = 2'd0;
      fixed = raw;
    end
    y.ns  = fixed[NS_W-1:0];
    y.sec = a.sec + b_sec + SEC_W'(wrap);
  end
endmodule

// File: rtl/wcp_tod_ge.sv
module wcp_tod_ge
  import wcp_pkg::*;
(
  input  tod_t now,
  input  tod_t due,
  output logic reached
);
  always_comb reached = ({now.sec, now.ns} >= {due.sec, due.ns});
endmodule

// File: rtl/wcp_regs.sv
module wcp_regs
  import wcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic              busy,
  input  logic              done,
  output cfg_t              cfg,
  output logic              start_req,
  output logic              stop_req,
  output logic              done_clr,
  output logic [REG_DW-1:0] rd_data
);
  logic [NS_W-1:0]  st_ns_q;
  logic [31:0]      st_lo_q;
  logic [HI_W-1:0]  st_hi_q;
  logic [DUR_W-1:0] width_q, gap_q;
  logic             rep_q, rel_q, inv_q;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ns_q <= '0;
      st_lo_q <= '0;
      st_hi_q <= '0;
      width_q <= '0;
      gap_q   <= '0;
      rep_q   <= 1'b0;
      rel_q   <= 1'b0;
      inv_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          rep_q <= wr_data[B_REP];
          rel_q <= wr_data[B_REL];
          inv_q <= wr_data[B_INV];
        end
        A_ST_NS: st_ns_q <= wr_data[NS_W-1:0];
        A_ST_LO: st_lo_q <= wr_data[31:0];
        A_ST_HI: st_hi_q <= wr_data[HI_W-1:0];
        A_WIDTH: width_q <= wr_data[DUR_W-1:0];
        A_GAP:   gap_q   <= wr_data[DUR_W-1:0];
        default: ;
      endcase
    end
  end

  // Mode bits written together with START take effect for that start.
  always_comb begin
    cfg.start.sec = {st_hi_q, st_lo_q};
    cfg.start.ns  = st_ns_q;
    cfg.width     = width_q;
    cfg.gap       = gap_q;
    cfg.rep       = ctrl_wr ? wr_data[B_REP] : rep_q;
    cfg.rel       = ctrl_wr ? wr_data[B_REL] : rel_q;
    cfg.inv       = ctrl_wr ? wr_data[B_INV] : inv_q;
  end

  assign start_req = ctrl_wr && wr_data[B_START];
  assign stop_req  = ctrl_wr && wr_data[B_STOP];
  assign done_clr  = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = REG_DW'({inv_q, rel_q, rep_q, 2'b00});
      A_STAT:  rd_data = REG_DW'({busy, done});
      A_ST_NS: rd_data = REG_DW'(st_ns_q);
      A_ST_LO: rd_data = st_lo_q;
      A_ST_HI: rd_data = REG_DW'(st_hi_q);
      A_WIDTH: rd_data = REG_DW'(width_q);
      A_GAP:   rd_data = REG_DW'(gap_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wcp_seq.sv
module wcp_seq
  import wcp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tod_t wall,
  input  cfg_t cfg_in,
  input  logic start_req,
  input  logic stop_req,
  input  logic done_clr,
  output logic pulse_out,
  output logic busy,
  output logic done
);
  seq_state_t       state;
  cfg_t             cfg_q;
  tod_t             deadline, base_sum, next_due;
  logic [DUR_W-1:0] step_dur;
  logic             lvl, inv_q, stop_pend, hit;
  logic             has_width;

  assign has_width = (cfg_q.width != '0);
  assign step_dur  = (state == S_ACT || !has_width) ? cfg_q.gap : cfg_q.width;

  wcp_tod_add u_base (
    .a(wall), .b_sec(cfg_in.start.sec), .b_ns(DUR_W'(cfg_in.start.ns)), .y(base_sum)
  );
  wcp_tod_add u_adv (
    .a(deadline), .b_sec('0), .b_ns(step_dur), .y(next_due)
  );
  wcp_tod_ge u_cmp (.now(wall), .due(deadline), .reached(hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cfg_q     <= '0;
      deadline  <= '0;
      lvl       <= 1'b0;
      inv_q     <= 1'b0;
      stop_pend <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (done_clr) done <= 1'b0;
      if (state != S_IDLE && stop_req) stop_pend <= 1'b1;
      case (state)
        S_IDLE: if (start_req) begin
          cfg_q     <= cfg_in;
          deadline  <= cfg_in.rel ? base_sum : cfg_in.start;
          lvl       <= 1'b0;
          inv_q     <= cfg_in.inv;
          stop_pend <= 1'b0;
          done      <= 1'b0;
          state     <= S_WAIT;
        end
        S_WAIT: if (hit) begin
          lvl      <= ~lvl;
          deadline <= next_due;
          state    <= has_width ? S_ACT : S_GAP;
        end
        S_ACT: if (hit) begin
          lvl      <= 1'b0;
          deadline <= next_due;
          state    <= S_GAP;
        end
        S_GAP: if (hit) begin
          if (!cfg_q.rep || stop_pend) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            lvl      <= has_width ? 1'b1 : ~lvl;
            deadline <= next_due;
            state    <= has_width ? S_ACT : S_GAP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pulse_out = lvl ^ inv_q;
  assign busy      = (state != S_IDLE);

  // R9: scheduled nanoseconds stay normalised
  p_ns_norm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({2'b00, deadline.ns} < NS_PER_SEC));
  // R2: no output movement while waiting for the start time
  p_wait_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && $past(state) == S_WAIT) |-> $stable(pulse_out));
  // R7: done only rises at the end of an inactive interval
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state) == S_GAP);
  // R10: a set done flag never coexists with a run in progress
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: a start during a run leaves the latched setup alone
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(cfg_q));
endmodule

// File: rtl/wallclock_pulse_gen.sv
module wallclock_pulse_gen
  import wcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  wall_sec,
  input  logic [NS_W-1:0]   wall_ns,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  output logic              pulse_out,
  output logic              done
);
  tod_t wall;
  cfg_t cfg;
  logic start_req, stop_req, done_clr, busy;

  assign wall.sec = wall_sec;
  assign wall.ns  = wall_ns;

  wcp_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .busy, .done, .cfg, .start_req, .stop_req, .done_clr, .rd_data
  );

  wcp_seq u_seq (
    .clk, .rst_n, .wall, .cfg_in(cfg), .start_req, .stop_req, .done_clr,
    .pulse_out, .busy, .done
  );
endmodule

// File: tb/sim_wallclock_pulse_gen.sv
module sim_wallclock_pulse_gen;
  import wcp_pkg::*;

  localparam longint unsigned BIL = 64'd1_000_000_000;
  localparam longint unsigned INF = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [SEC_W-1:0]  wall_sec;
  logic [NS_W-1:0]   wall_ns;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr, rd_addr;
  logic [REG_DW-1:0] wr_data, rd_data;
  logic              pulse_out, done;

  longint unsigned wall_t;
  longint unsigned step;
  assign wall_sec = SEC_W'(wall_t / BIL);
  assign wall_ns  = NS_W'(wall_t % BIL);

  wallclock_pulse_gen u0 (
    .clk, .rst_n, .wall_sec, .wall_ns, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .pulse_out, .done
  );

  int n_chk = 0, n_bad = 0;
  bit armed, first, dclr, mrep, minv;
  longint unsigned t0, endt, mw, mi;
  string tag;

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at wall %0d: actual %0d expected %0d", req, wall_t, act, exp);
    end
  endtask

  function automatic bit exp_lvl(longint unsigned t);
    longint unsigned k;
    if (t < t0) return 1'b0;
    if (mw == 0) begin
      k = (t - t0) / mi + 1;
      if (t >= endt) k = (endt - t0) / mi;
      return k[0];
    end
    if (t >= endt) return 1'b0;
    return ((t - t0) % (mw + mi)) < mw;
  endfunction

  task automatic tick();
    @(negedge clk);
    if (armed) begin
      if (first) begin
        check({tag, " R2 R5 wait level"}, pulse_out, minv);
        check({tag, " R10 done cleared by start"}, done, 0);
        first = 0;
      end else begin
        check({tag, " out"}, pulse_out, exp_lvl(wall_t) ^ minv);
        check({tag, " done"}, done, (wall_t >= endt) && !dclr);
      end
    end
    wr_en  = 1'b0;
    wall_t = wall_t + step;
  endtask

  task automatic wr(logic [REG_AW-1:0] a, logic [REG_DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic run_case(string t, bit rep, bit rel, bit inv, int unsigned w,
                          int unsigned i, int unsigned stp, longint signed off,
                          int stop_after, bit garbage, bit clr);
    longint unsigned sval, p, ts, k;
    logic [REG_DW-1:0] mode;
    tag = t; step = stp;
    sval = rel ? longint'(off) : longint'(wall_t) + off;
    wr(A_ST_NS, REG_DW'(sval % BIL));
    wr(A_ST_LO, REG_DW'((sval / BIL) & 64'hFFFF_FFFF));
    wr(A_ST_HI, REG_DW'((sval / BIL) >> 32));
    wr(A_WIDTH, REG_DW'(w));
    wr(A_GAP,   REG_DW'(i));
    mode = REG_DW'({inv, rel, rep, 2'b00});
    wr_en = 1'b1; wr_addr = A_CTRL; wr_data = mode | 32'd1;
    t0 = rel ? wall_t + sval : sval;
    mw = w; mi = i; mrep = rep; minv = inv;
    endt = rep ? INF : t0 + w + i;
    armed = 1; first = 1; dclr = 0;
    tick();
    for (int cyc = 0; cyc < 9000; cyc++) begin
      if (garbage && cyc == 2 && (endt == INF || endt > wall_t + 20 * step)) begin
        // R8: restart and new setup written mid-run must not matter
        wr(A_CTRL, REG_DW'({~inv, ~rel, ~rep, 2'b01}));
        wr(A_WIDTH, REG_DW'(w + 77));
        wr(A_GAP, REG_DW'(i + 33));
      end else if (rep && cyc == stop_after) begin
        ts = wall_t;
        p = (w == 0) ? i : w + i;
        k = (ts < t0) ? 1 : (ts - t0) / p + 1;
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = mode | 32'd2;
        endt = t0 + k * p;
        tick();
      end else begin
        tick();
      end
      if (endt != INF && wall_t > endt + 3 * step) break;
    end
    rd_addr = A_STAT; #1;
    check({tag, " R10 status after end"}, rd_data, 1);
    if (clr) begin
      wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'd1;
      dclr = 1;
      tick();
      tick();
      rd_addr = A_STAT; #1;
      check({tag, " R10 done w1c"}, rd_data, 0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned w, i, stp;
    bit rep, rel, inv;
    longint signed off;
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = A_STAT;
    wall_t = 64'd1000 * BIL + 64'd500; step = 10;
    armed = 0; first = 0; dclr = 0; tag = "";
    t0 = 0; endt = INF; mw = 1; mi = 1; mrep = 0; minv = 0;
    repeat (4) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 out", pulse_out, 0);
    check("R1 done", done, 0);
    check("R1 status", rd_data, 0);

    run_case("R4 single abs", 0, 0, 0, 200, 300, 10, 400, 0, 0, 1);
    run_case("R5 R3 active-low rel", 0, 1, 1, 150, 250, 7, 600, 0, 0, 0);
    run_case("R6 toggle single", 0, 0, 0, 0, 300, 9, 500, 0, 0, 1);
    run_case("R7 repeat pulse stop", 1, 0, 0, 120, 180, 11, 400, 60, 0, 1);
    run_case("R6 R7 repeat toggle stop", 1, 1, 1, 0, 140, 13, 300, 45, 0, 1);
    run_case("R11 past start", 0, 0, 0, 500, 200, 10, -20, 0, 0, 1);
    run_case("R8 busy restart", 0, 0, 1, 900, 400, 12, 600, 0, 1, 0);
    run_case("R8 R10 restart after done", 1, 0, 0, 100, 100, 8, 300, 70, 1, 1);
    wall_t = 64'hFFFF_FFFF * BIL + 64'd999_999_900;
    run_case("R9 R3 carry rel", 0, 1, 0, 60, 90, 5, 150, 0, 0, 1);
    run_case("R9 carry repeat", 1, 0, 0, 70, 80, 6, 300, 40, 0, 1);

    for (int n = 0; n < 24; n++) begin
      rep = 1'($urandom % 2);
      rel = 1'($urandom % 2);
      inv = 1'($urandom % 2);
      w   = ($urandom % 4 == 0) ? 0 : 30 + $urandom % 900;
      i   = 30 + $urandom % 900;
      stp = 3 + $urandom % 27;
      off = rel ? longint'($urandom % 2000) : longint'(6 * stp + $urandom % 2000);
      run_case("R2 R3 R4 R5 R6 R7 random", rep, rel, inv, w, i, stp, off,
               10 + int'($urandom % 120), 1'($urandom % 2), 1'($urandom % 2));
    end

    summary();
    $finish;
  end
endmodule